// File: doc/BRIEF.md
# UART Receive Path with Flagged FIFO and Interrupt Status

This block is the receive half of a serial port. A 2-flop synchronizer feeds a deserializer. The deserializer runs on a tick at 16 times the baud rate. It validates the start bit at mid-bit, shifts in 5 to 8 data bits least significant bit first, and can check a parity bit. It then samples the stop bit at its centre. Each character lands in a 16-entry FIFO together with three per-character flags: break, parity error and framing error.

Software sees the oldest entry on the read-data port and pops it with a one-cycle read strobe. Four status bits are kept: not-empty, overrun, level at or above a programmable threshold, and a stale-data timeout counted in character times. The interrupt line is the OR of the status bits whose mask bits are set. A one-cycle FIFO reset pulse discards all stored characters and clears the sticky status. The bus interface and the baud divider sit outside the block.

Top module: `uart_rx_fifo`

## Requirements
- R1: The FIFO holds 16 entries and `level_o` reports the count. A character that completes while 16 are stored is dropped and sets overrun (`stat_o[1]`). Overrun stays set, even across reads, until a FIFO reset.
- R2: Each read word carries the character in bits [7:0], break in bit 8, parity error in bit 9 and framing error in bit 10. Data bits above the character length read as zero, and the whole word reads as zero while the FIFO is empty.
- R3: `data_bits_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, received least significant bit first.
- R4: With `par_en_i` high, one parity bit follows the data. The parity is odd when `par_odd_i` is 1 and even when it is 0, and a mismatch sets bit 9. With `par_en_i` low, no parity bit is expected and bit 9 is 0.
- R5: When the stop bit samples low and the frame is not a break, the entry keeps its data and sets bit 10.
- R6: A break is a frame whose data bits, parity bit (if enabled) and stop bit all sample low. It pushes exactly one entry with value 0x100. No further entry is made until the line has returned high.
- R7: `stat_o[2]` is 1 exactly when `level_o >= thresh_i`.
- R8: A character time is 16 × (2 + data bits + parity bit) ticks. `stat_o[3]` sets once `tmo_chars_i` character times pass with the FIFO non-empty and no push or pop. A push, a pop or a FIFO reset clears it, and `tmo_chars_i` = 0 disables it.
- R9: `irq_o` is the OR of `stat_o & irq_mask_i`, where bit 0 is not-empty, bit 1 overrun, bit 2 threshold and bit 3 timeout. A zero mask holds `irq_o` low.
- R10: A one-cycle `fifo_rst_i` leaves `level_o` at 0 and clears overrun and timeout from the next cycle on.
- R11: While `rx_en_i` is low, frames on the line produce no entries.
- R12: A low pulse shorter than half a bit time is rejected as a false start and produces no entry.
- R13: A read strobe while the FIFO is empty has no effect; `level_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the baud rate |
| rx_en_i | input | 1 | Enables reception |
| data_bits_i | input | 2 | Character length code (0..3 selects 5..8 bits) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| thresh_i | input | 5 | Level threshold for status bit 2 |
| tmo_chars_i | input | 8 | Timeout in character times, 0 disables |
| irq_mask_i | input | 4 | Per-status interrupt enables |
| fifo_rst_i | input | 1 | Empties the FIFO and clears sticky status |
| rd_i | input | 1 | Pops the head entry |
| rd_data_o | output | 11 | Head entry: {ferr, perr, brk, data[7:0]} |
| level_o | output | 5 | Number of stored entries |
| stat_o | output | 4 | {timeout, threshold, overrun, not-empty} |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A character is pushed at the centre of its stop bit plus two synchronizer cycles. The bench therefore checks the FIFO only after the whole frame and one idle bit time, which is well past that point. Pops and FIFO resets act at the next edge, so level, status and head data are checked one cycle after the strobe and away from the edge. The timeout is checked in a window of about 550 clock cycles after the push, where it must still be clear, and again at about 750 cycles, where it must be set. These points sit on either side of the 640-cycle character time, so the tick phase and the synchronizer latency cannot shift a result across the boundary.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OSR_W = 4;   // 16x oversampling
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic              brk;
    logic [CHAR_W-1:0] data;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT_HI
  } rx_state_e;

  localparam int ST_NE  = 0;
  localparam int ST_OVR = 1;
  localparam int ST_THR = 2;
  localparam int ST_TMO = 3;
  localparam int ST_N   = 4;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic [1:0] bits_code_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic       push_o,
  output rx_word_t   word_o
);
  localparam logic [OSR_W-1:0] OS_MID  = OSR_W'((1 << OSR_W) / 2 - 1);
  localparam logic [OSR_W-1:0] OS_LAST = OSR_W'((1 << OSR_W) - 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         state_q;
  logic [OSR_W-1:0]  os_q;
  logic [2:0]        idx_q;
  logic [CHAR_W-1:0] data_q;
  logic              pbit_q;
  logic [2:0]        last_idx;
  logic              is_brk;

  assign rx_s     = sync_q[1];
  assign last_idx = 3'd4 + {1'b0, bits_code_i};
  assign is_brk   = !rx_s && (data_q == '0) && (!par_en_i || !pbit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      pbit_q  <= 1'b0;
      push_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      push_o <= 1'b0;
      if (!en_i) begin
        state_q <= S_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          S_IDLE: if (!rx_s) begin
            state_q <= S_START;
            os_q    <= '0;
          end
          S_START: begin
            if (os_q == OS_MID) begin
              os_q <= '0;
              if (!rx_s) begin
                state_q <= S_DATA;
                idx_q   <= '0;
                data_q  <= '0;
              end else begin
                state_q <= S_IDLE;   // false start
              end
            end else os_q <= os_q + 1'b1;
          end
          S_DATA: begin
            if (os_q == OS_LAST) begin
              os_q          <= '0;
              data_q[idx_q] <= rx_s;
              if (idx_q == last_idx) state_q <= par_en_i ? S_PAR : S_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else os_q <= os_q + 1'b1;
          end
          S_PAR: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              pbit_q  <= rx_s;
              state_q <= S_STOP;
            end else os_q <= os_q + 1'b1;
          end
          S_STOP: begin
            if (os_q == OS_LAST) begin
              os_q        <= '0;
              push_o      <= 1'b1;
              word_o.data <= is_brk ? '0 : data_q;
              word_o.brk  <= is_brk;
              word_o.perr <= !is_brk && par_en_i && ((^data_q ^ pbit_q) != par_odd_i);
              word_o.ferr <= !is_brk && !rx_s;
              state_q     <= rx_s ? S_IDLE : S_WAIT_HI;
            end else os_q <= os_q + 1'b1;
          end
          S_WAIT_HI: if (rx_s) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
  parameter int DEPTH = 16,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic          full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count_o == CW'(DEPTH));
  assign empty   = (count_o == '0);
  assign do_push = push_i && !full && !clr_i;
  assign do_pop  = pop_i && !empty && !clr_i;
  assign ovf_o   = push_i && full && !clr_i;
  assign dout_o  = empty ? '0 : mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      count_o <= count_o + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TMO_W  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             ovf_i,
  input  logic [CW-1:0]    count_i,
  input  logic [CW-1:0]    thresh_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic [7:0]       char_ticks_i,
  output logic [ST_N-1:0]  stat_o
);
  logic             ovr_q, tmo_q;
  logic [7:0]       tick_cnt_q;
  logic [TMO_W-1:0] char_cnt_q;
  logic             restart;

  assign restart = clr_i || push_i || pop_i || (count_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovr_q <= 1'b0;
    else if (clr_i)  ovr_q <= 1'b0;
    else if (ovf_i)  ovr_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
      char_cnt_q <= '0;
      tmo_q      <= 1'b0;
    end else if (restart) begin
      tick_cnt_q <= '0;
      char_cnt_q <= '0;
      tmo_q      <= 1'b0;
    end else if (tick_i && !tmo_q) begin
      if (tick_cnt_q == char_ticks_i - 8'd1) begin
        tick_cnt_q <= '0;
        char_cnt_q <= char_cnt_q + 1'b1;
        if (tmo_i != '0 && TMO_W'(char_cnt_q + 1'b1) == tmo_i) tmo_q <= 1'b1;
      end else begin
        tick_cnt_q <= tick_cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[ST_NE]  = (count_i != '0);
    stat_o[ST_OVR] = ovr_q;
    stat_o[ST_THR] = (count_i >= thresh_i);
    stat_o[ST_TMO] = tmo_q;
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TMO_W = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rx_en_i,
  input  logic [1:0]        data_bits_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [CW-1:0]     thresh_i,
  input  logic [TMO_W-1:0]  tmo_chars_i,
  input  logic [ST_N-1:0]   irq_mask_i,
  input  logic              fifo_rst_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CW-1:0]     level_o,
  output logic [ST_N-1:0]   stat_o,
  output logic              irq_o
);
  logic        push, ovf, pop_ok;
  rx_word_t    word;
  logic [3:0]  frame_bits;
  logic [7:0]  char_ticks;

  assign frame_bits = 4'd7 + {2'b00, data_bits_i} + {3'b000, par_en_i};
  assign char_ticks = {frame_bits, {OSR_W{1'b0}}};
  assign pop_ok     = rd_i && (level_o != '0);

  uart_rx_deser u_deser (
    .clk_i, .rst_ni, .rx_i, .tick_i,
    .en_i        (rx_en_i),
    .bits_code_i (data_bits_i),
    .par_en_i, .par_odd_i,
    .push_o      (push),
    .word_o      (word)
  );

  uart_rx_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i   (fifo_rst_i),
    .push_i  (push),
    .din_i   (word),
    .pop_i   (rd_i),
    .dout_o  (rd_data_o),
    .count_o (level_o),
    .ovf_o   (ovf)
  );

  uart_rx_status #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_status (
    .clk_i, .rst_ni, .tick_i,
    .clr_i        (fifo_rst_i),
    .push_i       (push),
    .pop_i        (pop_ok),
    .ovf_i        (ovf),
    .count_i      (level_o),
    .thresh_i,
    .tmo_i        (tmo_chars_i),
    .char_ticks_i (char_ticks),
    .stat_o
  );

  assign irq_o = |(stat_o & irq_mask_i);
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TMO_W = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_i,
  input logic              tick_i,
  input logic              rx_en_i,
  input logic [1:0]        data_bits_i,
  input logic              par_en_i,
  input logic              par_odd_i,
  input logic [CW-1:0]     thresh_i,
  input logic [TMO_W-1:0]  tmo_chars_i,
  input logic [ST_N-1:0]   irq_mask_i,
  input logic              fifo_rst_i,
  input logic              rd_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [CW-1:0]     level_o,
  input logic [ST_N-1:0]   stat_o,
  input logic              irq_o
);
  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));

  assert_ovr_when_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[ST_OVR]) |-> $past(level_o) == CW'(DEPTH));

  assert_tmo_needs_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[ST_TMO] |-> stat_o[ST_NE]);

  assert_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> (level_o == '0) && !stat_o[ST_OVR] && !stat_o[ST_TMO]);

  assert_disabled_no_push_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && $past(!rx_en_i)) |=> level_o <= $past(level_o));

  assert_empty_read_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0 && rd_i) |=> level_o <= CW'(1));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/sim_uart_rx_fifo.sv
module sim_uart_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 64;   // 16 ticks x 4 clocks

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx = 1'b1, tick = 1'b0, rx_en = 1'b0;
  logic [1:0]  dbits = 2'd3;
  logic        par_en = 1'b0, par_odd = 1'b0;
  logic [4:0]  thresh = 5'd16;
  logic [7:0]  tmo = 8'd0;
  logic [3:0]  mask = 4'd0;
  logic        frst = 1'b0, rd = 1'b0;
  logic [10:0] rdata;
  logic [4:0]  level;
  logic [3:0]  stat;
  logic        irq;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [10:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .rx_en_i(rx_en),
    .data_bits_i(dbits), .par_en_i(par_en), .par_odd_i(par_odd),
    .thresh_i(thresh), .tmo_chars_i(tmo), .irq_mask_i(mask),
    .fifo_rst_i(frst), .rd_i(rd), .rd_data_o(rdata), .level_o(level),
    .stat_o(stat), .irq_o(irq)
  );

  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      tick <= (c == 3);
      c = (c + 1) % 4;
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  function automatic logic [7:0] cmask(input int nb);
    return 8'((1 << nb) - 1);
  endfunction

  function automatic logic [10:0] exp_word(input logic [7:0] d, input int nb, input bit pe,
                                           input bit bp, input bit bs, input bit brk);
    if (brk) return 11'h100;
    return {bs, pe & bp, 1'b0, d & cmask(nb)};
  endfunction

  task automatic bit_time(input logic v);
    rx = v;
    wait_clks(BIT_CLKS);
  endtask

  // start, data LSB first, optional parity, stop, then idle
  task automatic send_frame(input logic [7:0] d, input bit bp, input bit bs, input bit brk);
    int  nb = 5 + int'(dbits);
    logic [7:0] m = brk ? 8'h00 : (d & cmask(nb));
    logic stop_v = !(brk || bs);
    bit_time(1'b0);
    for (int i = 0; i < nb; i++) bit_time(m[i]);
    if (par_en) bit_time(brk ? 1'b0 : ((^m) ^ par_odd ^ bp));
    bit_time(stop_v);
    if (brk) begin bit_time(1'b0); bit_time(1'b0); bit_time(1'b0); end
    if (!stop_v) bit_time(1'b1);
    bit_time(1'b1);
  endtask

  task automatic pop_chk(input string req, input logic [10:0] exp);
    chk(req, rdata, exp);
    rd = 1'b1;
    wait_clks(1);
    rd = 1'b0;
  endtask

  task automatic flush();
    frst = 1'b1;
    wait_clks(1);
    frst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(2);

    // reset state
    chk("R1 reset level", level, 0);
    chk("R9 reset stat", stat, 4'b0000);
    chk("R9 reset irq", irq, 0);
    chk("R2 empty word", rdata, 0);

    // R13: read on empty
    rd = 1'b1; wait_clks(1); rd = 1'b0; wait_clks(1);
    chk("R13 empty read level", level, 0);

    // R11: disabled receiver
    send_frame(8'h5A, 0, 0, 0);
    chk("R11 disabled no entry", level, 0);
    rx_en = 1'b1;
    wait_clks(4);

    // R12: short low glitch (4 ticks)
    rx = 1'b0; wait_clks(16); rx = 1'b1; wait_clks(3 * BIT_CLKS);
    chk("R12 glitch rejected", level, 0);

    // R3: each length code
    for (int c = 0; c < 4; c++) begin
      dbits = 2'(c);
      wait_clks(2);
      send_frame(8'hE7, 0, 0, 0);
      pop_chk("R3 length code", exp_word(8'hE7, 5 + c, 0, 0, 0, 0));
    end
    dbits = 2'd3;

    // R4: parity even/odd, good and bad
    par_en = 1'b1;
    for (int o = 0; o < 2; o++) begin
      par_odd = 1'(o);
      wait_clks(2);
      send_frame(8'h6B, 0, 0, 0);
      send_frame(8'h6B, 1, 0, 0);
      pop_chk("R4 parity good", 11'h06B);
      pop_chk("R4 parity bad", 11'h26B);
    end
    par_en = 1'b0; par_odd = 1'b0;
    wait_clks(2);

    // R5: framing error
    send_frame(8'h3C, 0, 1, 0);
    pop_chk("R5 framing flag", 11'h43C);

    // R6: break with parity enabled, line held low
    par_en = 1'b1;
    wait_clks(2);
    send_frame(8'h00, 0, 0, 1);
    chk("R6 one break entry", level, 1);
    pop_chk("R6 break word", 11'h100);
    par_en = 1'b0;
    wait_clks(2);

    // R7 threshold and R9 masking
    thresh = 5'd3;
    send_frame(8'h11, 0, 0, 0);
    send_frame(8'h22, 0, 0, 0);
    chk("R7 below threshold", stat[2], 0);
    mask = 4'b0100;
    wait_clks(1);
    chk("R9 masked threshold low", irq, 0);
    send_frame(8'h33, 0, 0, 0);
    chk("R7 at threshold", stat[2], 1);
    chk("R9 threshold irq", irq, 1);
    mask = 4'b0000;
    wait_clks(1);
    chk("R9 zero mask", irq, 0);
    mask = 4'b0001;
    wait_clks(1);
    chk("R9 not-empty irq", irq, 1);
    mask = 4'b0000;
    flush();
    chk("R10 level after flush", level, 0);
    chk("R10 status after flush", stat & 4'b1011, 0);
    thresh = 5'd16;

    // R1: fill and overflow
    for (int i = 0; i < 17; i++) send_frame(8'(i + 8'h40), 0, 0, 0);
    chk("R1 full level", level, 16);
    chk("R1 overrun set", stat[1], 1);
    pop_chk("R1 oldest kept", 11'h040);
    chk("R1 overrun sticky", stat[1], 1);
    chk("R1 level after pop", level, 15);
    flush();
    chk("R10 overrun cleared", stat[1], 0);
    chk("R10 emptied", level, 0);

    // R8: timeout one character time (640 clocks at 8N)
    tmo = 8'd1;
    mask = 4'b1000;
    wait_clks(2);
    send_frame(8'h77, 0, 0, 0);
    wait_clks(450);
    chk("R8 timeout not yet", stat[3], 0);
    wait_clks(200);
    chk("R8 timeout set", stat[3], 1);
    chk("R9 timeout irq", irq, 1);
    pop_chk("R8 timeout data", 11'h077);
    chk("R8 cleared by pop", stat[3], 0);
    tmo = 8'd0;
    send_frame(8'h78, 0, 0, 0);
    wait_clks(2000);
    chk("R8 disabled", stat[3], 0);
    pop_chk("R8 disabled data", 11'h078);
    mask = 4'b0000;

    // constrained random frames
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d = 8'($urandom);
      int  c  = int'($urandom % 4);
      bit  pe = bit'($urandom % 2);
      bit  od = bit'($urandom % 2);
      bit  bp = pe && ($urandom % 4 == 0);
      bit  bs = ($urandom % 6 == 0) && ((d & cmask(5 + c)) != 0);
      dbits = 2'(c); par_en = pe; par_odd = od;
      wait_clks(2);
      send_frame(d, bp, bs, 0);
      q.push_back(exp_word(d, 5 + c, pe, bp, bs, 0));
      if (i % 4 == 3) begin
        chk("R1 random level", level, 4);
        while (q.size() > 0) pop_chk("R2 random word", q.pop_front());
      end
    end

    summary();
  end
endmodule